// File: doc/BRIEF.md
# Temperature Monitor Control Register

This block is a single 8-bit control and status register that sits between a bus port and an on-die temperature sensing path. Software uses it to switch the sensor on, to pick which internal voltage (a temperature-proportional voltage or a bandgap reference) is routed to an internal converter channel, and to take an interrupt when the over-temperature status changes. The analog sensor, its comparator and the converter are outside the block. They appear only as digital inputs and outputs.

The comparator gives two separate indications: the die is above the assert threshold, or it is below the deassert threshold. The block keeps a latched status bit with hysteresis. Only full power mode with the sensor enabled lets the status bit be set. Any change of the status bit, in either direction, raises a sticky flag. Software clears the flag by writing 1 to it. Two test bits accept writes only in special mode.

Top module: `tmon_ctrl_reg`

## Requirements
- R1: After reset every register bit reads 0, the interrupt request is 0, the sensor enable is 0 and the channel source is external (code 00).
- R2: A bus write loads voltage select (bit 5), access enable (bit 4), sensor enable (bit 3) and interrupt enable (bit 1). Reads return them at the same positions. Writes to the status bit (bit 2) have no effect.
- R3: Test bits 7:6 take the written value only when specialMode is 1 during the write. Otherwise they keep their value.
- R4: chanSrc is 00 (external input) when access enable is 0. It is 01 (temperature voltage) when access enable is 1 and select is 0. It is 10 (bandgap) when both are 1.
- R5: With powerMode full (00) and sensor enable 1, overAssert high sets the status bit on the next clock. overAssert wins if both comparator indications are high.
- R6: Under the same conditions, belowDeassert alone clears the status bit on the next clock. With neither indication high, the status bit holds its value.
- R7: When powerMode is reduced (01), shutdown (10) or 11, or when sensor enable is 0, the status bit is 0 on the next clock.
- R8: The flag (bit 0) is set in the same clock in which the status bit changes, for a rise or a fall.
- R9: Writing 1 to bit 0 clears the flag and writing 0 leaves it. A status change in the same clock wins over the clear.
- R10: irq is 1 exactly when the flag and interrupt enable are both 1.
- R11: Entering reduced or shutdown power mode does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value |
| specialMode | input | 1 | Unlocks writes to the test bits |
| powerMode | input | 2 | 00 full, 01 reduced, 10 shutdown |
| overAssert | input | 1 | Die above the assert threshold |
| belowDeassert | input | 1 | Die below the deassert threshold |
| sensorEn | output | 1 | Sensor enable |
| chanSrc | output | 2 | Converter channel source: 00 external, 01 temperature, 10 bandgap |
| testBits | output | 2 | Test bits 7:6 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that powerMode and the comparator indications are synchronous to clk and hold steady across each edge. They also assume that overAssert and belowDeassert may both be high, with assert taking priority. The stimulus changes every input only on the falling edge. It draws the comparator pair from all four combinations and the power mode from all four codes, including the unused 11. Directed stretches cover hysteresis, simultaneous change and clear, and mode changes while the flag is pending.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    PM_FULL     = 2'b00,
    PM_REDUCED  = 2'b01,
    PM_SHUTDOWN = 2'b10,
    PM_UNUSED   = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    SRC_EXTERNAL = 2'b00,
    SRC_TEMP     = 2'b01,
    SRC_BANDGAP  = 2'b10
  } chan_src_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadCfg;
    logic       loadTest;
    logic       clearFlag;
    logic       statusArmed;
    logic [1:0] testVal;
    logic       selVal;
    logic       accVal;
    logic       senVal;
    logic       ieVal;
  } tmon_strobe_t;
endpackage

// File: rtl/tmon_ctrl.sv
module tmon_ctrl
  import tmon_pkg::*;
#(
  parameter int REG_WIDTH = REG_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_WIDTH-1:0] wrData,
  input  logic                 specialMode,
  input  logic [1:0]           powerMode,
  input  logic                 senCur,
  input  logic                 accCur,
  input  logic                 selCur,
  output tmon_strobe_t         strobe,
  output logic [1:0]           chanSrc
);
  localparam int BIT_SEL = 5;
  localparam int BIT_ACC = 4;
  localparam int BIT_SEN = 3;
  localparam int BIT_IE  = 1;
  localparam int BIT_FL  = 0;
  localparam int TEST_HI = REG_WIDTH - 1;
  localparam int TEST_LO = REG_WIDTH - 2;

  pwr_mode_e modeNow;
  assign modeNow = pwr_mode_e'(powerMode);

  always_comb begin
    strobe.loadCfg     = wrEn;
    strobe.loadTest    = wrEn && specialMode;
    strobe.clearFlag   = wrEn && wrData[BIT_FL];
    strobe.statusArmed = (modeNow == PM_FULL) && senCur;
    strobe.testVal     = wrData[TEST_HI:TEST_LO];
    strobe.selVal      = wrData[BIT_SEL];
    strobe.accVal      = wrData[BIT_ACC];
    strobe.senVal      = wrData[BIT_SEN];
    strobe.ieVal       = wrData[BIT_IE];
  end

  always_comb begin
    if (!accCur)     chanSrc = SRC_EXTERNAL;
    else if (selCur) chanSrc = SRC_BANDGAP;
    else             chanSrc = SRC_TEMP;
  end

  // R4: never both internal sources at once
  p_src_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanSrc));
  // R4: external whenever access is off
  p_src_ext_r4: assert property (@(posedge clk) disable iff (!rstN)
    !accCur |-> chanSrc == 2'b00);
endmodule

// File: rtl/tmon_datapath.sv
module tmon_datapath
  import tmon_pkg::*;
#(
  parameter int REG_WIDTH = REG_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tmon_strobe_t         strobe,
  input  logic                 overAssert,
  input  logic                 belowDeassert,
  output logic [REG_WIDTH-1:0] regView,
  output logic                 senReg,
  output logic                 accReg,
  output logic                 selReg,
  output logic [1:0]           testReg,
  output logic                 irqOut
);
  logic statusReg, ieReg, flagReg;
  logic statusNext, statusChange;

  always_comb begin
    if (!strobe.statusArmed) statusNext = 1'b0;
    else if (overAssert)     statusNext = 1'b1;
    else if (belowDeassert)  statusNext = 1'b0;
    else                     statusNext = statusReg;
  end
  assign statusChange = statusNext != statusReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= 1'b0;
      flagReg   <= 1'b0;
    end else begin
      statusReg <= statusNext;
      if (statusChange)          flagReg <= 1'b1;
      else if (strobe.clearFlag) flagReg <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= 1'b0;
      accReg <= 1'b0;
      senReg <= 1'b0;
      ieReg  <= 1'b0;
    end else if (strobe.loadCfg) begin
      selReg <= strobe.selVal;
      accReg <= strobe.accVal;
      senReg <= strobe.senVal;
      ieReg  <= strobe.ieVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                testReg <= 2'b00;
    else if (strobe.loadTest) testReg <= strobe.testVal;
  end

  assign regView = {testReg, selReg, accReg, senReg, statusReg, ieReg, flagReg};
  assign irqOut  = flagReg & ieReg;

  // R7: status low when not armed
  p_status_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.statusArmed |=> !statusReg);
  // R6: hysteresis hold
  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statusArmed && !overAssert && !belowDeassert) |=> $stable(statusReg));
  // R5: assert sets
  p_status_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statusArmed && overAssert) |=> statusReg);
  // R8: any change leaves the flag set
  p_flag_on_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusReg) |-> flagReg);
  // R9: clear without a change empties the flag
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearFlag && !statusChange) |=> !flagReg);
  // R3: test bits keep value without an unlocked write
  p_test_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadTest |=> testReg == $past(testReg));
endmodule

// File: rtl/tmon_ctrl_reg.sv
module tmon_ctrl_reg
  import tmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       specialMode,
  input  logic [1:0] powerMode,
  input  logic       overAssert,
  input  logic       belowDeassert,
  output logic       sensorEn,
  output logic [1:0] chanSrc,
  output logic [1:0] testBits,
  output logic       irq
);
  tmon_strobe_t strobe;
  logic senReg, accReg, selReg;

  tmon_ctrl #(.REG_WIDTH(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .specialMode(specialMode), .powerMode(powerMode),
    .senCur(senReg), .accCur(accReg), .selCur(selReg),
    .strobe(strobe), .chanSrc(chanSrc)
  );

  tmon_datapath #(.REG_WIDTH(REG_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .overAssert(overAssert), .belowDeassert(belowDeassert),
    .regView(rdData), .senReg(senReg), .accReg(accReg), .selReg(selReg),
    .testReg(testBits), .irqOut(irq)
  );

  assign sensorEn = senReg;

  // R11: a mode change alone never drops a pending flag
  p_flag_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && !(wrEn && wrData[0])) |=> rdData[0]);
endmodule

// File: tb/tmon_ctrl_reg_test.sv
module tmon_ctrl_reg_test;
  logic clk = 0, rstN = 0;
  logic wrEn = 0, specialMode = 0, overAssert = 0, belowDeassert = 0;
  logic [7:0] wrData = 0;
  logic [1:0] powerMode = 0;
  logic [7:0] rdData;
  logic sensorEn, irq;
  logic [1:0] chanSrc, testBits;

  int checks = 0, failures = 0;

  logic [1:0] mTest;
  logic mSel, mAcc, mSen, mSt, mIe, mFl;

  tmon_ctrl_reg uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [1:0] expSrc();
    return !mAcc ? 2'b00 : (mSel ? 2'b10 : 2'b01);
  endfunction

  function automatic logic [7:0] expReg();
    return {mTest, mSel, mAcc, mSen, mSt, mIe, mFl};
  endfunction

  task automatic checkAll();
    chk("R5/R6/R7 status", rdData[2], mSt);
    chk("R8/R9/R11 flag", rdData[0], mFl);
    chk("R2 config", {rdData[5:3], rdData[1]}, {mSel, mAcc, mSen, mIe});
    chk("R3 test bits", {rdData[7:6], testBits}, {mTest, mTest});
    chk("R4 source", chanSrc, expSrc());
    chk("R10 irq", irq, mFl & mIe);
    chk("R2 sensorEn", sensorEn, mSen);
  endtask

  // drive at negedge, model at posedge, check at next negedge
  task automatic step(logic w, logic [7:0] d, logic sp, logic [1:0] pm, logic oa, logic bd);
    logic stN, flN;
    wrEn = w; wrData = d; specialMode = sp; powerMode = pm;
    overAssert = oa; belowDeassert = bd;
    @(posedge clk);
    stN = (pm == 2'b00 && mSen) ? (oa ? 1'b1 : (bd ? 1'b0 : mSt)) : 1'b0;
    flN = (stN != mSt) ? 1'b1 : ((w && d[0]) ? 1'b0 : mFl);
    mSt = stN; mFl = flN;
    if (w) begin mSel = d[5]; mAcc = d[4]; mSen = d[3]; mIe = d[1]; end
    if (w && sp) mTest = d[7:6];
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    {mTest, mSel, mAcc, mSen, mSt, mIe, mFl} = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset reg", rdData, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset src", chanSrc, 0);
    rstN = 1;
    @(negedge clk);
    checkAll();
    // R2: status bit write ignored, config loaded
    step(1, 8'b0011_1110, 0, 0, 0, 0);
    chk("R2 status write ignored", rdData[2], 0);
    // R3: test bits locked in normal mode, open in special
    step(1, 8'b1101_1000, 0, 0, 0, 0);
    chk("R3 locked", testBits, 0);
    step(1, 8'b1100_1010, 1, 0, 0, 0);
    chk("R3 special write", testBits, 2'b11);
    // R5 set, R6 hold, R8 flag rise, R10 irq
    step(0, 0, 0, 0, 1, 0);
    chk("R5 set", rdData[2], 1);
    chk("R10 irq", irq, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R6 hold", rdData[2], 1);
    // R9 clear then R6 fall with flag
    step(1, 8'b0000_1011, 0, 0, 0, 0);
    chk("R9 clear", rdData[0], 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R6 clear", rdData[2], 0);
    chk("R8 fall sets flag", rdData[0], 1);
    // R9 set wins over clear
    step(1, 8'b0000_1011, 0, 0, 0, 0);
    step(1, 8'b0000_1011, 0, 0, 1, 0);
    chk("R9 set wins", rdData[0], 1);
    // R11/R7 reduced mode forces status low, flag kept
    step(0, 0, 0, 2'b01, 1, 0);
    chk("R7 reduced low", rdData[2], 0);
    step(0, 0, 0, 2'b01, 1, 0);
    chk("R11 flag kept", rdData[0], 1);
    // R4 routing
    step(1, 8'b0001_1000, 0, 0, 0, 0);
    chk("R4 temp", chanSrc, 2'b01);
    step(1, 8'b0011_1000, 0, 0, 0, 0);
    chk("R4 bandgap", chanSrc, 2'b10);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] pm;
      pm = ($urandom_range(0, 9) < 7) ? 2'b00 : 2'($urandom_range(1, 3));
      step(($urandom_range(0, 9) < 3), 8'($urandom), $urandom_range(0, 1) == 1,
           pm, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule